// File: doc/BRIEF.md
# Single-Round DES Coprocessor Datapath

This block is a DES datapath that a processor steps one Feistel round at a time through single-cycle commands. A key command loads a 64-bit key as two 32-bit words and keeps the 56 permuted key bits as two 28-bit rotating halves. A block command loads 64 bits of data and stores them in permuted form as left and right halves. A round command performs one round. It carries two qualifiers: a direction flag (encrypt or decrypt) and a flag that picks a key rotation of one or two positions.

The engine has no round counter and no sequencer. Software decides how many rounds run, in what order, and how far the key rotates in each one. A read command latches one 32-bit half of the output-permuted result onto the read port. Once the key has run a full schedule it is back at its start state, so the next block needs no key reload.

Top module: `des_round_engine`

## Requirements
- R1: After reset every state register is zero. `rd_word_o` reads 0, and a read of either half returns 0.
- R2: A key command (`cmd_key_i`, key = {`word_hi_i`,`word_lo_i`}, bit 63 = first DES bit) applies the 56-bit key selection and splits the result into two 28-bit rotating halves.
- R3: A block command (`cmd_data_i`, block = {`word_hi_i`,`word_lo_i`}) applies the input permutation and forms the left and right halves.
- R4: Each round sets new left = old right and new right = old left XOR f(old right, round key). f is expansion, XOR with the key, the eight substitution boxes, then the 32-bit permutation.
- R5: In an encrypt round (`mode_dec_i`=0), both key halves first rotate left by 1 (`shift_two_i`=0) or by 2 (`shift_two_i`=1). The round key is then selected from the rotated halves.
- R6: In a decrypt round (`mode_dec_i`=1), the round key is selected from the current halves. Both halves then rotate right by 1 or 2, as `shift_two_i` selects.
- R7: A read command (`cmd_read_i`) drives `rd_word_o` on the next clock edge. The value is the output permutation of {right, left}: bits 63:32 when `read_hi_i`=1, bits 31:0 when it is 0.
- R8: A round command in the same cycle as a block command or a key command has no effect. The load takes place and the key halves and data halves are not advanced.
- R9: Key 133457799BBCDFF1 and block 0123456789ABCDEF encrypted with left rotations 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1 read back as 85E81354 (high) and 0F0AB405 (low).
- R10: The ciphertext decrypted with right rotations 1,2,2,2,2,2,2,1,2,2,2,2,2,2,1,1 gives back the plaintext. After either schedule the key is at its start state, and a following block processes correctly without reloading the key.
- R11: With no command asserted, the key halves, data halves and `rd_word_o` hold their values. Idle cycles inserted between rounds do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_key_i | input | 1 | Load key from the two input words |
| cmd_data_i | input | 1 | Load data block from the two input words |
| cmd_round_i | input | 1 | Perform one Feistel round |
| cmd_read_i | input | 1 | Latch one result half onto the read port |
| mode_dec_i | input | 1 | Round direction: 0 encrypt, 1 decrypt |
| shift_two_i | input | 1 | Key rotation amount: 0 one position, 1 two positions |
| read_hi_i | input | 1 | Read half select: 1 high word, 0 low word |
| word_hi_i | input | 32 | High 32 bits of key or block |
| word_lo_i | input | 32 | Low 32 bits of key or block |
| rd_word_o | output | 32 | Registered result half |

## Verification
A round command can arrive in the same cycle as a block load or a key load, and the load has to win without the key schedule moving. The bench raises the round strobe together with each kind of load. It then runs the full 16-round encrypt schedule and compares the result with the known ciphertext. A round that had slipped through would shift the key halves or disturb the data halves, and the final words would no longer match.

// File: rtl/des_round_pkg.sv
package des_round_pkg;

    localparam int BLK_W  = 64;
    localparam int WORD_W = BLK_W / 2;
    localparam int KEY_W  = 56;
    localparam int HALF_W = KEY_W / 2;
    localparam int RK_W   = 48;
    localparam int NBOX   = 8;
    localparam int SB_IN  = RK_W / NBOX;
    localparam int SB_OUT = WORD_W / NBOX;

    typedef struct packed {
        logic [HALF_W-1:0] c;
        logic [HALF_W-1:0] d;
        logic [WORD_W-1:0] l;
        logic [WORD_W-1:0] r;
        logic [WORD_W-1:0] rd;
    } eng_state_t;

    // positions are 1-based, counted from the most significant bit
    localparam int IP_T [64] = '{
        58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
        62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
        57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
        61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

    localparam int PC1_T [56] = '{
        57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
        10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
        63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
        14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

    localparam int PC2_T [48] = '{
        14,17,11,24,1,5,  3,28,15,6,21,10,
        23,19,12,4,26,8,  16,7,27,20,13,2,
        41,52,31,37,47,55, 30,40,51,45,33,48,
        44,49,39,56,34,53, 46,42,50,36,29,32};

    localparam int P_T [32] = '{
        16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
        2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

    localparam int SB0_T [64] = '{
        14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
        0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
        4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
        15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
    localparam int SB1_T [64] = '{
        15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
        3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
        0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
        13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
    localparam int SB2_T [64] = '{
        10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
        13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
        13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
        1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
    localparam int SB3_T [64] = '{
        7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
        13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
        10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
        3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
    localparam int SB4_T [64] = '{
        2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
        14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
        4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
        11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
    localparam int SB5_T [64] = '{
        12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
        10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
        9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
        4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
    localparam int SB6_T [64] = '{
        4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
        13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
        1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
        6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
    localparam int SB7_T [64] = '{
        13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
        1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
        7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
        2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

    function automatic logic [BLK_W-1:0] perm_in(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-IP_T[i]];
        return y;
    endfunction

    // output permutation is the inverse of the input permutation
    function automatic logic [BLK_W-1:0] perm_out(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-IP_T[i]] = x[BLK_W-1-i];
        return y;
    endfunction

    function automatic logic [KEY_W-1:0] key_select(input logic [BLK_W-1:0] x);
        logic [KEY_W-1:0] y;
        for (int i = 0; i < KEY_W; i++) y[KEY_W-1-i] = x[BLK_W-PC1_T[i]];
        return y;
    endfunction

    function automatic logic [RK_W-1:0] rkey_select(input logic [KEY_W-1:0] x);
        logic [RK_W-1:0] y;
        for (int i = 0; i < RK_W; i++) y[RK_W-1-i] = x[KEY_W-PC2_T[i]];
        return y;
    endfunction

    function automatic logic [RK_W-1:0] expand(input logic [WORD_W-1:0] x);
        logic [RK_W-1:0] y;
        for (int g = 0; g < NBOX; g++) begin
            for (int j = 0; j < SB_IN; j++) begin
                y[RK_W-1-(SB_IN*g+j)] = x[WORD_W-1-((SB_OUT*g+j+WORD_W-1) % WORD_W)];
            end
        end
        return y;
    endfunction

    function automatic logic [WORD_W-1:0] perm_p(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] y;
        for (int i = 0; i < WORD_W; i++) y[WORD_W-1-i] = x[WORD_W-P_T[i]];
        return y;
    endfunction

    function automatic logic [SB_OUT-1:0] sbox_val(input int box, input logic [SB_IN-1:0] idx);
        case (box)
            0:       return SB_OUT'(SB0_T[idx]);
            1:       return SB_OUT'(SB1_T[idx]);
            2:       return SB_OUT'(SB2_T[idx]);
            3:       return SB_OUT'(SB3_T[idx]);
            4:       return SB_OUT'(SB4_T[idx]);
            5:       return SB_OUT'(SB5_T[idx]);
            6:       return SB_OUT'(SB6_T[idx]);
            default: return SB_OUT'(SB7_T[idx]);
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] rot_left(input logic [HALF_W-1:0] x, input logic two);
        return two ? {x[HALF_W-3:0], x[HALF_W-1:HALF_W-2]} : {x[HALF_W-2:0], x[HALF_W-1]};
    endfunction

    function automatic logic [HALF_W-1:0] rot_right(input logic [HALF_W-1:0] x, input logic two);
        return two ? {x[1:0], x[HALF_W-1:2]} : {x[0], x[HALF_W-1:1]};
    endfunction

endpackage

// File: rtl/des_key_step.sv
module des_key_step
    import des_round_pkg::*;
(
    input  logic [HALF_W-1:0] c_i,
    input  logic [HALF_W-1:0] d_i,
    input  logic              dec_i,
    input  logic              two_i,
    output logic [HALF_W-1:0] c_nx_o,
    output logic [HALF_W-1:0] d_nx_o,
    output logic [RK_W-1:0]   rkey_o
);
    logic [HALF_W-1:0] c_l, d_l;

    always_comb begin
        c_l = rot_left(c_i, two_i);
        d_l = rot_left(d_i, two_i);
        if (dec_i) begin
            // decrypt: select from current halves, then step backwards
            rkey_o = rkey_select({c_i, d_i});
            c_nx_o = rot_right(c_i, two_i);
            d_nx_o = rot_right(d_i, two_i);
        end else begin
            // encrypt: step forwards, then select
            rkey_o = rkey_select({c_l, d_l});
            c_nx_o = c_l;
            d_nx_o = d_l;
        end
    end
endmodule

// File: rtl/des_sbox.sv
module des_sbox
    import des_round_pkg::*;
#(
    parameter int BOX = 0
) (
    input  logic [SB_IN-1:0]  x_i,
    output logic [SB_OUT-1:0] y_o
);
    logic [SB_IN-1:0] idx;

    // row from the two outer bits, column from the four inner bits
    assign idx = {x_i[SB_IN-1], x_i[0], x_i[SB_IN-2:1]};
    assign y_o = sbox_val(BOX, idx);
endmodule

// File: rtl/des_fbox.sv
module des_fbox
    import des_round_pkg::*;
(
    input  logic [WORD_W-1:0] r_i,
    input  logic [RK_W-1:0]   k_i,
    output logic [WORD_W-1:0] f_o
);
    logic [RK_W-1:0]   mixed;
    logic [WORD_W-1:0] sub;

    assign mixed = expand(r_i) ^ k_i;

    for (genvar g = 0; g < NBOX; g++) begin : g_box
        des_sbox #(.BOX(g)) u_sbox (
            .x_i (mixed[RK_W-1-SB_IN*g -: SB_IN]),
            .y_o (sub[WORD_W-1-SB_OUT*g -: SB_OUT])
        );
    end

    assign f_o = perm_p(sub);
endmodule

// File: rtl/des_round_engine.sv
module des_round_engine
    import des_round_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cmd_key_i,
    input  logic        cmd_data_i,
    input  logic        cmd_round_i,
    input  logic        cmd_read_i,
    input  logic        mode_dec_i,
    input  logic        shift_two_i,
    input  logic        read_hi_i,
    input  logic [31:0] word_hi_i,
    input  logic [31:0] word_lo_i,
    output logic [31:0] rd_word_o
);
    eng_state_t st_d, st_q;

    logic [HALF_W-1:0] c_nx_d, d_nx_d;
    logic [RK_W-1:0]   rkey_d;
    logic [WORD_W-1:0] f_d;
    logic [KEY_W-1:0]  ksel_d;
    logic [BLK_W-1:0]  blk_d;
    logic [BLK_W-1:0]  res_d;
    logic              step_d;

    des_key_step u_key_step (
        .c_i    (st_q.c),
        .d_i    (st_q.d),
        .dec_i  (mode_dec_i),
        .two_i  (shift_two_i),
        .c_nx_o (c_nx_d),
        .d_nx_o (d_nx_d),
        .rkey_o (rkey_d)
    );

    des_fbox u_fbox (
        .r_i (st_q.r),
        .k_i (rkey_d),
        .f_o (f_d)
    );

    always_comb begin
        st_d   = st_q;
        ksel_d = key_select({word_hi_i, word_lo_i});
        blk_d  = perm_in({word_hi_i, word_lo_i});
        res_d  = perm_out({st_q.r, st_q.l});
        // any load in the same cycle cancels the round
        step_d = cmd_round_i && !cmd_key_i && !cmd_data_i;

        if (cmd_key_i) begin
            st_d.c = ksel_d[KEY_W-1:HALF_W];
            st_d.d = ksel_d[HALF_W-1:0];
        end
        if (cmd_data_i) begin
            st_d.l = blk_d[BLK_W-1:WORD_W];
            st_d.r = blk_d[WORD_W-1:0];
        end
        if (step_d) begin
            st_d.c = c_nx_d;
            st_d.d = d_nx_d;
            st_d.l = st_q.r;
            st_d.r = st_q.l ^ f_d;
        end
        if (cmd_read_i) begin
            st_d.rd = read_hi_i ? res_d[BLK_W-1:WORD_W] : res_d[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_word_o = st_q.rd;
endmodule

// File: rtl/des_round_engine_chk.sv
module des_round_engine_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        cmd_key_i,
    input logic        cmd_data_i,
    input logic        cmd_round_i,
    input logic        cmd_read_i,
    input logic        mode_dec_i,
    input logic        shift_two_i,
    input logic [27:0] c_q,
    input logic [27:0] d_q,
    input logic [31:0] l_q,
    input logic [31:0] r_q,
    input logic [31:0] rd_word_o
);
    logic step;
    logic idle;
    assign step = cmd_round_i && !cmd_key_i && !cmd_data_i;
    assign idle = !cmd_key_i && !cmd_data_i && !cmd_round_i && !cmd_read_i;

    assert_round_swap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step |=> l_q == $past(r_q));

    assert_enc_rot1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step && !mode_dec_i && !shift_two_i |=> c_q == {$past(c_q[26:0]), $past(c_q[27])});

    assert_dec_rot2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step && mode_dec_i && shift_two_i |=> d_q == {$past(d_q[1:0]), $past(d_q[27:2])});

    assert_read_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_read_i |=> $stable(rd_word_o));

    assert_data_blocks_round_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_round_i && cmd_data_i && !cmd_key_i |=> $stable(c_q) && $stable(d_q));

    assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle |=> $stable(c_q) && $stable(d_q) && $stable(l_q) && $stable(r_q));
endmodule

bind des_round_engine des_round_engine_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_key_i   (cmd_key_i),
    .cmd_data_i  (cmd_data_i),
    .cmd_round_i (cmd_round_i),
    .cmd_read_i  (cmd_read_i),
    .mode_dec_i  (mode_dec_i),
    .shift_two_i (shift_two_i),
    .c_q         (st_q.c),
    .d_q         (st_q.d),
    .l_q         (st_q.l),
    .r_q         (st_q.r),
    .rd_word_o   (rd_word_o)
);

// File: tb/des_round_engine_bench.sv
module des_round_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_key = 1'b0, cmd_data = 1'b0, cmd_round = 1'b0, cmd_read = 1'b0;
    logic        mode_dec = 1'b0, shift_two = 1'b0, read_hi = 1'b0;
    logic [31:0] w_hi = '0, w_lo = '0;
    logic [31:0] rd_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [63:0] KEY = 64'h133457799BBCDFF1;
    localparam logic [63:0] PT  = 64'h0123456789ABCDEF;
    localparam logic [63:0] CT  = 64'h85E813540F0AB405;

    always #4 clk = ~clk;

    des_round_engine u_des_round_engine (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmd_key_i   (cmd_key),
        .cmd_data_i  (cmd_data),
        .cmd_round_i (cmd_round),
        .cmd_read_i  (cmd_read),
        .mode_dec_i  (mode_dec),
        .shift_two_i (shift_two),
        .read_hi_i   (read_hi),
        .word_hi_i   (w_hi),
        .word_lo_i   (w_lo),
        .rd_word_o   (rd_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic bit two_for(input bit dec, input int i);
        if (dec) return !(i == 0 || i == 7 || i == 14 || i == 15);
        return !(i == 0 || i == 1 || i == 8 || i == 15);
    endfunction

    // all tasks start and end at a falling edge
    task automatic load_key(input logic [63:0] k, input bit with_round);
        cmd_key = 1'b1; cmd_round = with_round; mode_dec = 1'b0; shift_two = 1'b1;
        {w_hi, w_lo} = k;
        @(negedge clk);
        cmd_key = 1'b0; cmd_round = 1'b0;
    endtask

    task automatic load_block(input logic [63:0] b, input bit with_round);
        cmd_data = 1'b1; cmd_round = with_round; mode_dec = 1'b0; shift_two = 1'b0;
        {w_hi, w_lo} = b;
        @(negedge clk);
        cmd_data = 1'b0; cmd_round = 1'b0;
    endtask

    task automatic run16(input bit dec, input bit gaps);
        for (int i = 0; i < 16; i++) begin
            cmd_round = 1'b1; mode_dec = dec; shift_two = two_for(dec, i);
            @(negedge clk);
            cmd_round = 1'b0;
            if (gaps) repeat (i % 3 + 1) @(negedge clk);
        end
    endtask

    task automatic read_word(input bit hi, output logic [31:0] v);
        cmd_read = 1'b1; read_hi = hi;
        @(negedge clk);
        cmd_read = 1'b0;
        v = rd_word;
    endtask

    task automatic read_both(input string req, input logic [63:0] exp);
        logic [31:0] v;
        read_word(1'b1, v); check(req, v, exp[63:32]);
        read_word(1'b0, v); check(req, v, exp[31:0]);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 rd after reset", rd_word, 32'h0);
        read_both("R1 zero state", 64'h0);
    endtask

    task automatic t_encrypt_kat;
        load_key(KEY, 1'b0);
        load_block(PT, 1'b0);
        run16(1'b0, 1'b0);
        read_both("R9 R2 R3 R4 R5 R7 encrypt", CT);
    endtask

    task automatic t_read_hold;
        logic [31:0] v;
        read_word(1'b1, v);
        repeat (3) @(negedge clk);
        check("R11 idle hold", rd_word, CT[63:32]);
        cmd_round = 1'b1; @(negedge clk); cmd_round = 1'b0;
        check("R7 no read keeps word", rd_word, CT[63:32]);
    endtask

    task automatic t_decrypt;
        load_key(KEY, 1'b0);
        load_block(CT, 1'b0);
        run16(1'b1, 1'b0);
        read_both("R6 R10 decrypt", PT);
    endtask

    task automatic t_back_to_back;
        load_block(PT, 1'b0);
        run16(1'b0, 1'b0);
        read_both("R10 key returns to start", CT);
    endtask

    task automatic t_collide_data;
        load_key(KEY, 1'b0);
        load_block(PT, 1'b1);
        run16(1'b0, 1'b0);
        read_both("R8 round with block load", CT);
    endtask

    task automatic t_collide_key;
        load_key(KEY, 1'b1);
        load_block(PT, 1'b0);
        run16(1'b0, 1'b0);
        read_both("R8 round with key load", CT);
    endtask

    task automatic t_gaps;
        load_key(KEY, 1'b0);
        load_block(PT, 1'b0);
        run16(1'b0, 1'b1);
        read_both("R11 idle between rounds", CT);
    endtask

    task automatic t_reset_midrun;
        load_key(KEY, 1'b0);
        load_block(PT, 1'b0);
        run16(1'b0, 1'b0);
        do_reset();
        check("R1 reset clears read port", rd_word, 32'h0);
        read_both("R1 reset mid-run", 64'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_encrypt_kat();
        t_read_hold();
        t_decrypt();
        t_back_to_back();
        t_collide_data();
        t_collide_key();
        t_gaps();
        t_reset_midrun();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule